// File: doc/BRIEF.md
# MDIO Management Controller

This block gives software one 32-bit command/result word for reaching the management registers of external PHYs over a two-wire serial management bus. A single store holds the whole command: a busy flag, the direction, the PHY address, the register address and the data to send. The controller then builds the serial frame, drives the management clock and data lines, and for a read turns the data line around and collects the PHY's reply.

When the frame ends, hardware clears the busy flag. On a read it also places the returned 16 bits in the low half of the same word. Software starts a transaction and polls the flag until it drops. A store that arrives while a transaction is still running is thrown away. The management clock comes from the system clock through a divider derived from two parameters. It idles low between frames, and the data line is released while nothing is being sent.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command word reads 0x00000000, mdc_o is low and mdio_oe_o is 0. The clock stays low and the data line stays released whenever the busy flag (bit 31) is 0.
- R2: A store with bit 31 set, made while bit 31 reads 0, starts one frame. Bit 31 reads 1 from the following cycle until the frame is complete, then returns to 0.
- R3: A write frame (bit 30 = 1) sends, in order and MSB first: 32 ones, the start bits 01, the opcode 01, the 5-bit PHY address, the 5-bit register address, the turnaround 10 and the 16 data bits. mdio_oe_o is 1 for all 64 bits, and the word keeps its stored value apart from bit 31.
- R4: A read frame (bit 30 = 0) sends 32 ones, 01 and the opcode 10, then both addresses, with mdio_oe_o = 1. mdio_oe_o is 0 for the 2 turnaround bits and the 16 data bits. Data is sampled on each rising edge of mdc_o, MSB first, and the result replaces bits 15:0 while bits 30:16 stay as stored.
- R5: mdc_o has a half period of ceil(CLK_HZ / (2*MDC_MAX_HZ)) system cycles, which is 50 cycles with the default parameters, so it is never faster than MDC_MAX_HZ. mdio_o and mdio_oe_o change only while mdc_o is low.
- R6: A store made while bit 31 reads 1 is ignored. The word keeps its value and no second frame is sent.
- R7: A store with bit 31 clear updates the word but sends no frame.
- R8: A write of 0x8000 to register 0 (the PHY reset command) is sent as an ordinary write frame.
- R9: The field positions are fixed: the PHY address sits in bits 25:21 and the register address in bits 20:16. All-ones addresses are sent unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Store strobe for the command word |
| reg_wdata_i | input | 32 | Command word value to store |
| reg_rdata_o | output | 32 | Current command/result word |
| mdc_o | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Management data driven by the controller |
| mdio_oe_o | output | 1 | Drive enable for mdio_o (0 = released) |
| mdio_i | input | 1 | Management data seen on the bus |

## Verification
The assertions watch, on every cycle, the properties that hold at any point in time. These are the idle state of the clock and data lines while the flag is clear, the flag staying set until completion, stores being dropped while busy, a minimum low time on the clock, and the data line changing only while the clock is low. Bit ordering, opcodes, turnaround release, the sampled read value landing in the low half and the measured clock period depend on a whole frame. Only the bench scenarios can show these: a PHY model records each bit at the rising clock edge and replies during reads.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned TA_POS     = 46;  // first turnaround bit
  localparam int unsigned DATA_POS   = 48;  // first data bit

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef struct packed {
    logic        req;
    logic        wr;
    logic [3:0]  spare;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned HALF_DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(HALF_DIV + 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = run_i && wrap && !mdc_q;
  assign fall_o = run_i && wrap && mdc_q;

  // low-time monitor, saturating
  logic [CW:0] low_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             low_cnt_q <= (CW+1)'(HALF_DIV);
    else if (mdc_q)                          low_cnt_q <= '0;
    else if (low_cnt_q < (CW+1)'(HALF_DIV))  low_cnt_q <= low_cnt_q + 1'b1;
  end

  assert_mdc_low_time_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_q) |-> (low_cnt_q >= (CW+1)'(HALF_DIV)));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        wr_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  regad_i,
  input  logic [15:0] wdata_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic                  busy_q, done_q, rd_q;
  logic [5:0]            cnt_q;
  logic [FRAME_BITS-1:0] sh_q, frame_d;
  logic [15:0]           cap_q;

  assign frame_d = {32'hFFFF_FFFF, 2'b01, (wr_i ? OP_WR : OP_RD), phy_i, regad_i,
                    2'b10, (wr_i ? wdata_i : 16'hFFFF)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        rd_q   <= !wr_i;
        cnt_q  <= '0;
        sh_q   <= frame_d;
        cap_q  <= '0;
      end else if (busy_q) begin
        if (rise_i && rd_q && cnt_q >= 6'(DATA_POS))
          cap_q <= {cap_q[14:0], mdio_i};
        if (fall_i) begin
          if (cnt_q == 6'(FRAME_BITS - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rdata_o   = cap_q;
  assign mdio_o    = busy_q ? sh_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe_o = busy_q && !(rd_q && cnt_q >= 6'(TA_POS));

  assert_done_after_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(busy_q) && $past(fall_i)));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 250_000_000,
  parameter int unsigned MDC_MAX_HZ = 2_500_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int unsigned HALF_RAW = (CLK_HZ + 2*MDC_MAX_HZ - 1) / (2*MDC_MAX_HZ);
  localparam int unsigned HALF_DIV = (HALF_RAW < 2) ? 2 : HALF_RAW;

  cmd_t        ctrl_q, wcmd;
  logic        accept, start, busy, done, rise, fall;
  logic [15:0] rd_data;

  assign wcmd   = cmd_t'(reg_wdata_i);
  assign accept = reg_wr_i && !ctrl_q.req;
  assign start  = accept && wcmd.req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (done) begin
      ctrl_q.req <= 1'b0;
      if (!ctrl_q.wr) ctrl_q.data <= rd_data;
    end else if (accept) begin
      ctrl_q <= wcmd;
    end
  end

  assign reg_rdata_o = ctrl_q;

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_shifter u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .wr_i      (wcmd.wr),
    .phy_i     (wcmd.phy),
    .regad_i   (wcmd.regad),
    .wdata_i   (wcmd.data),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .rdata_o   (rd_data),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  assert_idle_lines_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.req |-> (!mdc_o && !mdio_oe_o));

  assert_req_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.req && !done) |=> ctrl_q.req);

  assert_busy_store_dropped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && ctrl_q.req && !done) |=> (reg_rdata_o[30:0] == $past(reg_rdata_o[30:0])));

  assert_data_stable_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mdio_mgmt_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .mdc_o(mdc_o), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  // PHY model
  int        rise_cnt = 0;
  logic      cap_val [0:63];
  logic      cap_oe  [0:63];
  logic [15:0] phy_word = '0;
  realtime   t_r0 = 0, t_r1 = 0;

  always @(posedge mdc_o) begin
    if (rise_cnt < 64) begin
      cap_val[rise_cnt] = mdio_o;
      cap_oe[rise_cnt]  = mdio_oe_o;
    end
    if (rise_cnt == 0) t_r0 = $realtime;
    if (rise_cnt == 1) t_r1 = $realtime;
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge mdc_o) begin
    if (rise_cnt >= 48 && rise_cnt <= 63) mdio_i = phy_word[63 - rise_cnt];
    else mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] v);
    @(negedge clk);
    reg_wr_i = 1'b1;
    reg_wdata_i = v;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (reg_rdata_o[31] && n < 10000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic [31:0] mk_cmd(input bit req, input bit wr, input logic [4:0] phy,
                                         input logic [4:0] ra, input logic [15:0] d);
    return {req, wr, 4'b0, phy, ra, d};
  endfunction

  task automatic check_frame(input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] wd, input string req);
    logic [63:0] exp = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra, 2'b10, wd};
    int errs = 0;
    for (int k = 0; k < 64; k++) begin
      bit eo = wr || (k < 46);
      if (cap_oe[k] !== eo) errs++;
      else if (eo && cap_val[k] !== exp[63-k]) errs++;
    end
    chk(errs == 0 && rise_cnt == 64, req, 64'(errs), 64'(0));
  endtask

  // R2 R3 R4 R8 R9: one full transaction
  task automatic t_xfer(input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                        input logic [15:0] wd, input logic [15:0] pd, input string req);
    logic [31:0] cmd = mk_cmd(1'b1, wr, phy, ra, wd);
    rise_cnt = 0;
    phy_word = pd;
    reg_write(cmd);
    chk(reg_rdata_o === cmd, {req, " R2 busy set"}, 64'(reg_rdata_o), 64'(cmd));
    wait_done();
    chk(reg_rdata_o[31] === 1'b0, {req, " R2 busy clear"}, 64'(reg_rdata_o[31]), 64'(0));
    check_frame(wr, phy, ra, wd, {req, " frame"});
    begin
      logic [31:0] ew = mk_cmd(1'b0, wr, phy, ra, wr ? wd : pd);
      chk(reg_rdata_o === ew, {req, " result word"}, 64'(reg_rdata_o), 64'(ew));
    end
    chk(!mdc_o && !mdio_oe_o, "R1 idle after frame", {62'b0, mdc_o, mdio_oe_o}, 64'(0));
  endtask

  task automatic t_reset();
    chk(reg_rdata_o === 32'h0, "R1 word after reset", 64'(reg_rdata_o), 64'(0));
    chk(!mdc_o && !mdio_oe_o, "R1 lines after reset", {62'b0, mdc_o, mdio_oe_o}, 64'(0));
  endtask

  task automatic t_period();
    rise_cnt = 0;
    reg_write(mk_cmd(1'b1, 1'b1, 5'd3, 5'd4, 16'h1234));
    wait_done();
    chk((t_r1 - t_r0) == 400.0, "R5 mdc period 100 cycles",
        64'(int'(t_r1 - t_r0)), 64'(400));
  endtask

  task automatic t_busy_store();
    logic [31:0] a = mk_cmd(1'b1, 1'b1, 5'd9, 5'd2, 16'h0F0F);
    rise_cnt = 0;
    reg_write(a);
    repeat (1000) @(negedge clk);
    reg_write(mk_cmd(1'b1, 1'b0, 5'd1, 5'd1, 16'hDEAD));
    chk(reg_rdata_o === a, "R6 store while busy dropped", 64'(reg_rdata_o), 64'(a));
    wait_done();
    check_frame(1'b1, 5'd9, 5'd2, 16'h0F0F, "R6 original frame only");
    repeat (300) @(negedge clk);
    chk(rise_cnt == 64, "R6 no second frame", 64'(rise_cnt), 64'(64));
  endtask

  task automatic t_no_req();
    logic [31:0] v = mk_cmd(1'b0, 1'b1, 5'd7, 5'd8, 16'hBEEF);
    rise_cnt = 0;
    reg_write(v);
    chk(reg_rdata_o === v, "R7 word updated", 64'(reg_rdata_o), 64'(v));
    repeat (300) @(negedge clk);
    chk(rise_cnt == 0 && !mdc_o, "R7 no frame sent", 64'(rise_cnt), 64'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_xfer(1'b1, 5'd5, 5'd0, 16'h8000, 16'h0, "R8 R3 phy reset write");
    t_xfer(1'b1, 5'd31, 5'd31, 16'hA5C3, 16'h0, "R9 R3 all-ones address write");
    t_xfer(1'b0, 5'd6, 5'd1, 16'h0000, 16'h782D, "R4 read");
    t_xfer(1'b0, 5'd0, 5'd0, 16'h0000, 16'hFFFF, "R4 read ones");
    t_xfer(1'b0, 5'd17, 5'd22, 16'h0000, 16'h0001, "R4 R9 read low bit");
    t_period();
    t_busy_store();
    t_no_req();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule